// File: doc/BRIEF.md
# Set/Clear Alias Control Register Bank

A bank of 32-bit control words on a simple memory-mapped write/read bus. It holds reset-control, clock-stop and strap words. Each word has two addresses. At the base address a write ORs the data into the word. One word higher, a write clears every bit that is 1 in the data. Software can therefore change single bits without a read-modify-write sequence.

The two strap words also have a guard word two words above their base. While the guard holds any nonzero value, writes to the OR path of that strap are dropped. The clear path keeps working. The extension words of the PLLs always read back with their lock flag (bit 31) set. Revision and identity words cannot be written. A key word reports whether the correct unlock value was last written. A locked bank still accepts writes, but each write raises a one-cycle warning pulse.

Reads are combinational from the current address. Writes take effect at the rising clock edge while the write strobe is high. Addresses are byte offsets, and the two low bits are ignored.

Top module: `scb_alias_bank`

## Requirements
- R1: A write to 0x040, 0x050, 0x080 or 0x090 ORs the write data into that word; bits already set stay set.
- R2: A write to 0x044, 0x054, 0x084 or 0x094 clears, in the word 4 bytes below, each bit that is 1 in the write data; other bits are kept.
- R3: A write to strap base 0x500 or 0x510 ORs the data in only while its guard word (0x508 or 0x510+8 = 0x518) reads zero; otherwise the word is unchanged. The guard words read back what was written.
- R4: Writes to the strap clear addresses 0x504 and 0x514 clear bits whether or not the guard word is nonzero, and a clear never sets a bit.
- R5: Reads of 0x204, 0x224 and 0x244 return the stored word with bit 31 forced to 1.
- R6: Writes to 0x004, 0x014, 0x540, 0x5B0 and 0x5B4 change nothing. 0x5B0 and 0x5B4 read the identity constants (defaults 0x1234ABCD and 0x88884444).
- R7: After reset, the words read as follows:
  - 0x040 = 0xF7C3FED8, 0x050 = 0x0DFFFFFC, 0x080 = 0xFFFF7F8A, 0x090 = 0xFFF0FFF0 and 0x200 = 0x1000408F.
  - 0x004 reads the revision parameter.
  - 0x014, 0x500 and 0x510 read the boot input ports.
- R8: A write to 0x000 stores a key flag of 1 only when the data equals the key parameter, and 0 for any other data. 0x000 reads the flag in bit 0. Writes are carried out whatever the flag.
- R9: `lock_warn` is high for exactly the one cycle after a write to any offset other than 0x000 made while the key flag is 0, and low otherwise (including after reset).
- R10: Clear addresses and unmapped offsets read 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| boot_strap_a | input | 32 | Value loaded into strap word 0x500 at reset |
| boot_strap_b | input | 32 | Value loaded into strap word 0x510 at reset |
| boot_rev_id | input | 32 | Value loaded into read-only word 0x014 at reset |
| lock_warn | output | 1 | One-cycle pulse after a write made while locked |

## Verification
The bench builds the block with the default address width. It overrides the key and revision parameters with values of its own, so the key compare and the revision readback are tested against numbers the default could not match by chance. The boot ports carry distinct patterns, so a strap mixed up with the other strap or with the revision word shows as a mismatch. The chosen strap and alias data make every OR, clear and dropped write change the readback, which brings the guard-versus-clear asymmetry and the forced lock bit within reach.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int DW        = 32;
  localparam int NUM_ALIAS = 6;
  localparam int NUM_GUARD = 2;
  localparam int NUM_PLAIN = NUM_ALIAS - NUM_GUARD;
  localparam int NUM_EXT   = 3;
  localparam int LOCK_BIT  = 31;

  // Alias base offsets; the last NUM_GUARD entries are the guarded straps.
  localparam logic [DW-1:0] ALIAS_OFF [NUM_ALIAS] = '{
    32'h040, 32'h050, 32'h080, 32'h090, 32'h500, 32'h510};
  localparam logic [DW-1:0] ALIAS_RST [NUM_PLAIN] = '{
    32'hF7C3FED8, 32'h0DFFFFFC, 32'hFFFF7F8A, 32'hFFF0FFF0};
  localparam logic [DW-1:0] EXT_OFF [NUM_EXT] = '{32'h204, 32'h224, 32'h244};

  localparam logic [DW-1:0] CLR_STEP   = 32'h4;
  localparam logic [DW-1:0] GUARD_STEP = 32'h8;

  localparam logic [DW-1:0] OFF_KEY  = 32'h000;
  localparam logic [DW-1:0] OFF_REV  = 32'h004;
  localparam logic [DW-1:0] OFF_REV2 = 32'h014;
  localparam logic [DW-1:0] OFF_PLL  = 32'h200;
  localparam logic [DW-1:0] OFF_RNG  = 32'h540;
  localparam logic [DW-1:0] OFF_ID0  = 32'h5B0;
  localparam logic [DW-1:0] OFF_ID1  = 32'h5B4;
  localparam logic [DW-1:0] PLL_RST  = 32'h1000408F;

  function automatic logic word_hit(input logic [DW-1:0] a, input logic [DW-1:0] off);
    return a[DW-1:2] == off[DW-1:2];
  endfunction

  function automatic logic [DW-1:0] bits_or(input logic [DW-1:0] q, input logic [DW-1:0] d);
    return q | d;
  endfunction

  function automatic logic [DW-1:0] bits_knock(input logic [DW-1:0] q, input logic [DW-1:0] d);
    return q & ~d;
  endfunction

  function automatic logic [DW-1:0] with_lock(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    r[LOCK_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/scb_wdecode.sv
module scb_wdecode
  import scb_pkg::*;
(
  input  logic          wr_en,
  input  logic [DW-1:0] bus_addr,
  output logic          set_we  [NUM_ALIAS],
  output logic          clr_we  [NUM_ALIAS],
  output logic          prot_we [NUM_GUARD],
  output logic          ext_we  [NUM_EXT],
  output logic          key_we,
  output logic          pll_we,
  output logic          upper_hit
);
  always_comb begin
    for (int i = 0; i < NUM_ALIAS; i++) begin
      set_we[i] = wr_en && word_hit(bus_addr, ALIAS_OFF[i]);
      clr_we[i] = wr_en && word_hit(bus_addr, ALIAS_OFF[i] + CLR_STEP);
    end
    for (int g = 0; g < NUM_GUARD; g++)
      prot_we[g] = wr_en && word_hit(bus_addr, ALIAS_OFF[NUM_PLAIN + g] + GUARD_STEP);
    for (int e = 0; e < NUM_EXT; e++)
      ext_we[e] = wr_en && word_hit(bus_addr, EXT_OFF[e]);
    key_we    = wr_en && word_hit(bus_addr, OFF_KEY);
    pll_we    = wr_en && word_hit(bus_addr, OFF_PLL);
    upper_hit = !word_hit(bus_addr, OFF_KEY);
  end
endmodule

// File: rtl/scb_alias_reg.sv
module scb_alias_reg
  import scb_pkg::*;
#(
  parameter bit GUARDED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rst_val,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          guard_open,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic set_fire;
  assign set_fire = set_we && (!GUARDED || guard_open);

  always_ff @(posedge clk) begin
    if (!rst_n)        q <= rst_val;
    else if (set_fire) q <= bits_or(q, wdata);
    else if (clr_we)   q <= bits_knock(q, wdata);
  end

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n) (set_we && guard_open) |=> ((q & $past(wdata)) == $past(wdata))); // R1
  AST_CLR_DROPS_ONES: assert property (@(posedge clk) disable iff (!rst_n) clr_we |=> ((q & $past(wdata)) == '0)); // R2
  AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n) clr_we |=> ((q & ~$past(q)) == '0)); // R4

  generate
    if (GUARDED) begin : g_guard_chk
      AST_GUARD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (set_we && !guard_open) |=> (q == $past(q))); // R3
    end
  endgenerate
endmodule

// File: rtl/scb_rd_mux.sv
module scb_rd_mux
  import scb_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID     = 32'h0,
  parameter logic [DW-1:0] CHIP_ID_LO = 32'h0,
  parameter logic [DW-1:0] CHIP_ID_HI = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_addr,
  input  logic          key_q,
  input  logic [DW-1:0] rev2_q,
  input  logic [DW-1:0] pll_q,
  input  logic [DW-1:0] alias_q [NUM_ALIAS],
  input  logic [DW-1:0] prot_q  [NUM_GUARD],
  input  logic [DW-1:0] ext_q   [NUM_EXT],
  output logic [DW-1:0] rdata,
  output logic          ext_rd_hit
);
  always_comb begin
    rdata      = '0;
    ext_rd_hit = 1'b0;
    if (word_hit(bus_addr, OFF_KEY))  rdata = {{(DW-1){1'b0}}, key_q};
    if (word_hit(bus_addr, OFF_REV))  rdata = REV_ID;
    if (word_hit(bus_addr, OFF_REV2)) rdata = rev2_q;
    if (word_hit(bus_addr, OFF_PLL))  rdata = pll_q;
    if (word_hit(bus_addr, OFF_ID0))  rdata = CHIP_ID_LO;
    if (word_hit(bus_addr, OFF_ID1))  rdata = CHIP_ID_HI;
    if (word_hit(bus_addr, OFF_RNG))  rdata = '0;
    for (int i = 0; i < NUM_ALIAS; i++)
      if (word_hit(bus_addr, ALIAS_OFF[i])) rdata = alias_q[i];
    for (int g = 0; g < NUM_GUARD; g++)
      if (word_hit(bus_addr, ALIAS_OFF[NUM_PLAIN + g] + GUARD_STEP)) rdata = prot_q[g];
    for (int e = 0; e < NUM_EXT; e++)
      if (word_hit(bus_addr, EXT_OFF[e])) begin
        rdata      = with_lock(ext_q[e]);
        ext_rd_hit = 1'b1;
      end
  end

  AST_LOCK_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n) ext_rd_hit |-> rdata[LOCK_BIT]); // R5
endmodule

// File: rtl/scb_alias_bank.sv
module scb_alias_bank
  import scb_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [DW-1:0]   KEY_MAGIC  = 32'h5A17_C0DE,
  parameter logic [DW-1:0]   REV_ID     = 32'h0503_0001,
  parameter logic [DW-1:0]   CHIP_ID_LO = 32'h1234ABCD,
  parameter logic [DW-1:0]   CHIP_ID_HI = 32'h88884444
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     boot_strap_a,
  input  logic [DW-1:0]     boot_strap_b,
  input  logic [DW-1:0]     boot_rev_id,
  output logic              lock_warn
);
  localparam int PAD_W = DW - ADDR_W;

  logic [DW-1:0] bus_addr;
  assign bus_addr = {{PAD_W{1'b0}}, addr};

  logic set_we  [NUM_ALIAS];
  logic clr_we  [NUM_ALIAS];
  logic prot_we [NUM_GUARD];
  logic ext_we  [NUM_EXT];
  logic key_we, pll_we, upper_hit;

  logic          key_q;
  logic [DW-1:0] rev2_q, pll_q;
  logic [DW-1:0] alias_q   [NUM_ALIAS];
  logic [DW-1:0] alias_rst [NUM_ALIAS];
  logic          guard_open[NUM_ALIAS];
  logic [DW-1:0] prot_q    [NUM_GUARD];
  logic [DW-1:0] ext_q     [NUM_EXT];
  logic          ext_rd_hit;
  logic          locked_write;

  scb_wdecode u_wdecode (
    .wr_en     (wr_en),
    .bus_addr  (bus_addr),
    .set_we    (set_we),
    .clr_we    (clr_we),
    .prot_we   (prot_we),
    .ext_we    (ext_we),
    .key_we    (key_we),
    .pll_we    (pll_we),
    .upper_hit (upper_hit)
  );

  generate
    for (genvar i = 0; i < NUM_ALIAS; i++) begin : g_alias
      if (i < NUM_PLAIN) begin : g_plain
        assign alias_rst[i]  = ALIAS_RST[i];
        assign guard_open[i] = 1'b1;
      end else begin : g_strap
        assign alias_rst[i]  = (i == NUM_PLAIN) ? boot_strap_a : boot_strap_b;
        assign guard_open[i] = (prot_q[i-NUM_PLAIN] == '0);
      end
      scb_alias_reg #(.GUARDED(i >= NUM_PLAIN)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_val    (alias_rst[i]),
        .set_we     (set_we[i]),
        .clr_we     (clr_we[i]),
        .guard_open (guard_open[i]),
        .wdata      (wdata),
        .q          (alias_q[i])
      );
    end
  endgenerate

  assign locked_write = wr_en && upper_hit && !key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q     <= 1'b0;
      rev2_q    <= boot_rev_id;
      pll_q     <= PLL_RST;
      lock_warn <= 1'b0;
      for (int g = 0; g < NUM_GUARD; g++) prot_q[g] <= '0;
      for (int e = 0; e < NUM_EXT; e++)   ext_q[e]  <= '0;
    end else begin
      if (key_we) key_q <= (wdata == KEY_MAGIC);
      if (pll_we) pll_q <= wdata;
      for (int g = 0; g < NUM_GUARD; g++) if (prot_we[g]) prot_q[g] <= wdata;
      for (int e = 0; e < NUM_EXT; e++)   if (ext_we[e])  ext_q[e]  <= wdata;
      lock_warn <= locked_write;
    end
  end

  scb_rd_mux #(
    .REV_ID     (REV_ID),
    .CHIP_ID_LO (CHIP_ID_LO),
    .CHIP_ID_HI (CHIP_ID_HI)
  ) u_rd_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .key_q      (key_q),
    .rev2_q     (rev2_q),
    .pll_q      (pll_q),
    .alias_q    (alias_q),
    .prot_q     (prot_q),
    .ext_q      (ext_q),
    .rdata      (rdata),
    .ext_rd_hit (ext_rd_hit)
  );

  AST_WARN_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && upper_hit && !key_q) |=> lock_warn); // R9
  AST_WARN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && upper_hit && !key_q) |=> !lock_warn); // R9
  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (key_we && wdata != KEY_MAGIC) |=> !key_q); // R8
  AST_KEY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (key_we && wdata == KEY_MAGIC) |=> key_q); // R8
endmodule

// File: tb/test_scb_alias_bank.sv
module test_scb_alias_bank;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [31:0] MAGIC      = 32'hC001_D00D;
  localparam logic [31:0] REV        = 32'h0611_0207;
  localparam logic [31:0] STRAP_A    = 32'h0000_00F0;
  localparam logic [31:0] STRAP_B    = 32'h1234_0000;
  localparam logic [31:0] REV2       = 32'hA5A5_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lock_warn;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scb_alias_bank #(.KEY_MAGIC(MAGIC), .REV_ID(REV)) i_scb_alias_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .boot_strap_a(STRAP_A), .boot_strap_b(STRAP_B), .boot_rev_id(REV2), .lock_warn(lock_warn));

  // Vector table: op 1 = write, 0 = read and compare with data.
  localparam int NV = 34;
  localparam logic        V_OP   [NV] = '{1,0,1,0,0,1,0,1,0,1,0,1,0,1,1,0,1,0,1,0,1,0,0,1,0,1,0,1,0,0,1,1,0,0};
  localparam logic [11:0] V_ADDR [NV] = '{12'h040,12'h040,12'h044,12'h040,12'h044,12'h050,12'h050,12'h094,12'h090,
    12'h080,12'h080,12'h500,12'h500,12'h508,12'h500,12'h500,12'h504,12'h500,12'h510,12'h510,12'h224,12'h224,
    12'h244,12'h5B0,12'h5B0,12'h014,12'h014,12'h300,12'h300,12'h514,12'h518,12'h514,12'h510,12'h518};
  localparam logic [31:0] V_DATA [NV] = '{32'h00000001,32'hF7C3FED9,32'hF0000000,32'h07C3FED9,32'h0,
    32'hF0000000,32'hFDFFFFFC,32'h0000FFFF,32'hFFF00000,32'h00008075,32'hFFFFFFFF,32'h0000000F,32'h000000FF,
    32'h00000001,32'h0000FF00,32'h000000FF,32'h0000000F,32'h000000F0,32'h00000001,32'h12340001,32'h00000123,
    32'h80000123,32'h80000000,32'h0,32'h1234ABCD,32'h0,32'hA5A50001,32'hFFFFFFFF,32'h0,32'h0,32'h00000002,
    32'h00000001,32'h12340000,32'h00000002};
  // Requirement per entry: R1 OR path, R2 clear path, R3 guarded straps, R4 ungated strap clear,
  // R5 lock bit on extension reads, R6 read-only words, R10 clear aliases and unmapped offsets.
  localparam int          V_REQ  [NV] = '{1,1,2,2,10,1,1,2,2,1,1,3,3,3,3,3,4,4,3,3,5,5,5,6,6,6,6,10,10,10,4,4,4,3};

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset defaults
    chk(9, {31'b0, lock_warn}, 32'h0);  // R9 quiet after reset
    bus_rd(12'h040, v); chk(7, v, 32'hF7C3FED8);
    bus_rd(12'h050, v); chk(7, v, 32'h0DFFFFFC);
    bus_rd(12'h080, v); chk(7, v, 32'hFFFF7F8A);
    bus_rd(12'h090, v); chk(7, v, 32'hFFF0FFF0);
    bus_rd(12'h200, v); chk(7, v, 32'h1000408F);
    bus_rd(12'h004, v); chk(7, v, REV);
    bus_rd(12'h014, v); chk(7, v, REV2);
    bus_rd(12'h500, v); chk(7, v, STRAP_A);
    bus_rd(12'h510, v); chk(7, v, STRAP_B);
    bus_rd(12'h5B4, v); chk(6, v, 32'h88884444);   // R6 identity word
    bus_rd(12'h204, v); chk(5, v, 32'h80000000);   // R5 lock bit after reset
    bus_rd(12'h000, v); chk(8, v, 32'h0);          // R8 key flag starts clear

    for (int k = 0; k < NV; k++) begin
      if (V_OP[k]) bus_wr(V_ADDR[k], V_DATA[k]);
      else begin
        bus_rd(V_ADDR[k], v);
        chk(V_REQ[k], v, V_DATA[k]);
      end
    end

    // R9 warning pulse: one cycle after a locked write, then gone
    bus_wr(12'h040, 32'h0);
    chk(9, {31'b0, lock_warn}, 32'h1);
    @(negedge clk);
    chk(9, {31'b0, lock_warn}, 32'h0);
    // R8 wrong key leaves flag clear; offset 0x000 raises no warning (R9)
    bus_wr(12'h000, MAGIC ^ 32'h1);
    chk(9, {31'b0, lock_warn}, 32'h0);
    bus_rd(12'h000, v); chk(8, v, 32'h0);
    bus_wr(12'h000, MAGIC);
    bus_rd(12'h000, v); chk(8, v, 32'h1);
    bus_wr(12'h080, 32'h0);
    chk(9, {31'b0, lock_warn}, 32'h0);            // R9 unlocked write is silent
    bus_wr(12'h000, 32'h0);
    bus_rd(12'h000, v); chk(8, v, 32'h0);
    // R8 locked bank still accepts writes
    bus_wr(12'h054, 32'h0DFFFFFC);
    bus_rd(12'h050, v); chk(8, v, 32'hF0000000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule